// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Target

This block is a read-only target on a two-wire I2C bus, sitting in front of an 8192-byte array. SCL and SDA come in as levels sampled by the fast system clock. The block finds START, repeated START and STOP from those samples. It compares the 7-bit device address in each header with a fixed 4-bit prefix followed by three strap pins. It answers by pulling SDA low through an output-enable line. A 13-bit address pointer stays valid from one transaction to the next.

A read header with no address phase returns the byte at the pointer. A write header followed by two address bytes loads the pointer. A repeated START and a read header then return the byte at the loaded address. While the controller keeps acknowledging, bytes keep coming out and the pointer advances after each one. A separate synchronous port fills the array for testing. Writing data through the bus is not supported.

Top module: `i2c_mem_reader`

## Requirements
- R1: After reset, sdaOe is 0, the bus state is idle and the address pointer is 0.
- R2: A header whose upper seven bits equal 4'b1010 followed by strap[2:0] is acknowledged. Bit 0 of the header selects read (1) or write (0). Any other header is not acknowledged, and the block leaves SDA released until the next START.
- R3: After an acknowledged read header, the block sends the byte stored at the pointer, most significant bit first, with one bit per SCL clock.
- R4: After a write header, the block acknowledges two address bytes. Bits 4:0 of the first byte become pointer bits 12:8, and its bits 7:5 are ignored. The second byte becomes pointer bits 7:0. A repeated START and a read header then return the byte at that address.
- R5: When the controller acknowledges a data byte, the block sends the byte at the next address.
- R6: The pointer wraps from 8191 to 0.
- R7: The pointer advances by one after every byte sent, including the last byte before NoACK. The next current-address read therefore returns the following location.
- R8: A write header and two address bytes followed by STOP change only the pointer. A later current-address read returns the byte at the loaded address.
- R9: A START (SDA falling while SCL is high) restarts header reception from any state. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. An address phase cut short by either one leaves the pointer unchanged.
- R10: sdaOe changes only while SCL is low, and the block releases SDA during the controller's acknowledge clock.
- R11: When loadEn is high on a clock edge, loadData is written to array location loadAddr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level, as seen on the wired line |
| strap | input | 3 | Low three bits of the device address |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |
| loadEn | input | 1 | Preload write strobe |
| loadAddr | input | 13 | Preload address |
| loadData | input | 8 | Preload byte |

## Verification
The assertions take for granted that SDA changes only while SCL is low, except for START and STOP. They also take for granted that each SCL level lasts several system clocks, longer than the synchronizer and the state register together. Under those conditions, a change on sdaOe, which follows a detected SCL fall, always lands while SCL is still low. The bench holds every SCL phase for eight clocks and moves its own SDA only during the low phase. It never places a START or STOP in a bit slot where the block is pulling SDA low.

// File: rtl/i2c_mem_reader_pkg.sv
package i2c_mem_reader_pkg;

  typedef struct packed {
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic hiLoad;
    logic ptrLoad;
    logic ptrInc;
  } imrStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_HDR_ACK,
    ST_ADR_HI,
    ST_ACK_HI,
    ST_ADR_LO,
    ST_ACK_LO,
    ST_HOLD,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } imrState_t;

endpackage

// File: rtl/i2c_mem_reader_dp.sv
module i2c_mem_reader_dp
  import i2c_mem_reader_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  imrStrobe_t        strb,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData,
  output logic              sclLvl,
  output logic              sdaLvl,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic [7:0]        rxByte,
  output logic              txBit
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;

  logic [2:0]        sclPipe, sdaPipe;
  logic              sclPrev, sdaPrev;
  logic [HI_W-1:0]   hiStage;
  logic [ADDR_W-1:0] ptrReg;
  logic [7:0]        txReg;
  logic [7:0]        memArr [DEPTH];

  // two-flop synchronizer plus one stage of history for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[1:0], sclIn};
      sdaPipe <= {sdaPipe[1:0], sdaIn};
    end
  end

  assign sclLvl   = sclPipe[1];
  assign sdaLvl   = sdaPipe[1];
  assign sclPrev  = sclPipe[2];
  assign sdaPrev  = sdaPipe[2];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte  <= '0;
      hiStage <= '0;
      ptrReg  <= '0;
    end else begin
      if (strb.rxShift) rxByte <= {rxByte[6:0], sdaLvl};
      if (strb.hiLoad)  hiStage <= rxByte[HI_W-1:0];
      if (strb.ptrLoad)     ptrReg <= {hiStage, rxByte};
      else if (strb.ptrInc) ptrReg <= ptrReg + 1'b1;
    end
  end

  // array and output shifter carry no reset
  always_ff @(posedge clk) begin
    if (loadEn) memArr[loadAddr] <= loadData;
    if (strb.txLoad)       txReg <= memArr[ptrReg];
    else if (strb.txShift) txReg <= {txReg[6:0], 1'b1};
  end

  assign txBit = txReg[7];

  // pointer moves by exactly one per increment strobe, wrapping at the top
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ptrInc && !strb.ptrLoad) |=> ptrReg == ADDR_W'($past(ptrReg) + 1));

  // pointer is untouched without a load or increment strobe
  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ptrInc && !strb.ptrLoad) |=> $stable(ptrReg));

endmodule

// File: rtl/i2c_mem_reader_ctl.sv
module i2c_mem_reader_ctl
  import i2c_mem_reader_pkg::*;
#(
  parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclLvl,
  input  logic       sdaLvl,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  input  logic [2:0] strap,
  output imrStrobe_t strb,
  output logic       sdaOe
);
  imrState_t  state, stateNxt;
  logic [3:0] bitCnt, bitCntNxt;
  logic       clkSeen, clkSeenNxt;
  logic       rdDir, rdDirNxt;
  logic       ctlAck, ctlAckNxt;
  logic       byteDone, hdrMatch;

  assign byteDone = (bitCnt == 4'd8);
  assign hdrMatch = (rxByte[7:1] == {DEV_PREFIX, strap});

  always_comb begin
    stateNxt   = state;
    bitCntNxt  = bitCnt;
    clkSeenNxt = clkSeen;
    rdDirNxt   = rdDir;
    ctlAckNxt  = ctlAck;
    strb       = '0;
    if (stopDet) begin
      stateNxt   = ST_IDLE;
      bitCntNxt  = '0;
      clkSeenNxt = 1'b0;
    end else if (startDet) begin
      stateNxt   = ST_HDR;
      bitCntNxt  = '0;
      clkSeenNxt = 1'b0;
    end else begin
      unique case (state)
        ST_HDR, ST_ADR_HI, ST_ADR_LO: begin
          if (sclRise && !byteDone) begin
            strb.rxShift = 1'b1;
            bitCntNxt    = bitCnt + 1'b1;
          end else if (sclFall && byteDone) begin
            bitCntNxt = '0;
            if (state == ST_HDR) begin
              rdDirNxt = rxByte[0];
              stateNxt = hdrMatch ? ST_HDR_ACK : ST_SKIP;
            end else if (state == ST_ADR_HI) begin
              strb.hiLoad = 1'b1;
              stateNxt    = ST_ACK_HI;
            end else begin
              strb.ptrLoad = 1'b1;
              stateNxt     = ST_ACK_LO;
            end
          end
        end
        ST_HDR_ACK, ST_ACK_HI, ST_ACK_LO: begin
          if (sclRise) clkSeenNxt = 1'b1;
          else if (sclFall && clkSeen) begin
            clkSeenNxt = 1'b0;
            if (state == ST_HDR_ACK) begin
              if (rdDir) begin
                strb.txLoad = 1'b1;
                stateNxt    = ST_TX;
              end else stateNxt = ST_ADR_HI;
            end else if (state == ST_ACK_HI) stateNxt = ST_ADR_LO;
            else stateNxt = ST_HOLD;
          end
        end
        ST_TX: begin
          if (sclRise && !byteDone) bitCntNxt = bitCnt + 1'b1;
          else if (sclFall && byteDone) begin
            bitCntNxt   = '0;
            strb.ptrInc = 1'b1;
            stateNxt    = ST_TX_ACK;
          end else if (sclFall) strb.txShift = 1'b1;
        end
        ST_TX_ACK: begin
          if (sclRise) begin
            clkSeenNxt = 1'b1;
            ctlAckNxt  = ~sdaLvl;
          end else if (sclFall && clkSeen) begin
            clkSeenNxt = 1'b0;
            if (ctlAck) begin
              strb.txLoad = 1'b1;
              stateNxt    = ST_TX;
            end else stateNxt = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      clkSeen <= 1'b0;
      rdDir   <= 1'b0;
      ctlAck  <= 1'b0;
    end else begin
      state   <= stateNxt;
      bitCnt  <= bitCntNxt;
      clkSeen <= clkSeenNxt;
      rdDir   <= rdDirNxt;
      ctlAck  <= ctlAckNxt;
    end
  end

  assign sdaOe = (state == ST_HDR_ACK) || (state == ST_ACK_HI) ||
                 (state == ST_ACK_LO) || ((state == ST_TX) && !txBit);

  assert_start_hdr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (startDet && !stopDet) |=> state == ST_HDR);

  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE && !sdaOe));

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclLvl);

  assert_ack_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_HDR && state == ST_HDR_ACK) |->
      $past(rxByte[7:1]) == {DEV_PREFIX, strap});

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

endmodule

// File: rtl/i2c_mem_reader.sv
module i2c_mem_reader
  import i2c_mem_reader_pkg::*;
#(
  parameter int         ADDR_W     = 13,
  parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        strap,
  output logic              sdaOe,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [7:0]        loadData
);
  imrStrobe_t strb;
  logic       sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet, txBit;
  logic [7:0] rxByte;

  i2c_mem_reader_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .rxByte(rxByte), .txBit(txBit)
  );

  i2c_mem_reader_ctl #(.DEV_PREFIX(DEV_PREFIX)) u_ctl (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sdaLvl(sdaLvl),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .rxByte(rxByte), .txBit(txBit), .strap(strap),
    .strb(strb), .sdaOe(sdaOe)
  );

endmodule

// File: tb/test_i2c_mem_reader.sv
`timescale 1ns/1ps
module test_i2c_mem_reader;
  localparam int ADDR_W = 13;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int Q      = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              mScl = 1'b1;
  logic              mSda = 1'b1;
  logic [2:0]        strap = 3'b101;
  logic              sdaOe;
  logic              sdaBus;
  logic              loadEn = 1'b0;
  logic [ADDR_W-1:0] loadAddr = '0;
  logic [7:0]        loadData = '0;
  int                nChecks = 0;
  int                nFails = 0;
  int                oeViol = 0;
  int                expPtr = 0;
  bit                finished = 1'b0;
  logic              prevOe = 1'b0;

  assign sdaBus = mSda & ~sdaOe;

  always #2.5 clk = ~clk;

  i2c_mem_reader i_i2c_mem_reader (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .strap(strap),
    .sdaOe(sdaOe), .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData)
  );

  // R10 monitor: an output-enable change while SCL is high is a violation
  always @(negedge clk) begin
    if (rstN && (sdaOe !== prevOe) && mScl) oeViol++;
    prevOe <= sdaOe;
  end

  function automatic logic [7:0] pat(int a);
    return 8'((a * 29) ^ (a >> 5) ^ 8'h3C);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic writeBit(input logic b);
    mSda = b; waitQ();
    mScl = 1'b1; waitQ();
    mScl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) writeBit(b[i]);
    mSda = 1'b1; waitQ();
    mScl = 1'b1;
    repeat (Q / 2) @(negedge clk);
    acked = ~sdaBus;
    repeat (Q / 2) @(negedge clk);
    mScl = 1'b0;
  endtask

  task automatic readByte(input bit mAck, output logic [7:0] d);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      mScl = 1'b1;
      repeat (Q / 2) @(negedge clk);
      d[i] = sdaBus;
      repeat (Q / 2) @(negedge clk);
      mScl = 1'b0;
    end
    mSda = ~mAck; waitQ();
    mScl = 1'b1;
    repeat (Q / 2) @(negedge clk);
    check(sdaOe == 1'b0, "R10 released in ack clock", int'(sdaOe), 0);
    repeat (Q / 2) @(negedge clk);
    mScl = 1'b0;
    waitQ();
    mSda = 1'b1;
  endtask

  function automatic logic [7:0] hdr(bit rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic curRead(string req);
    bit a;
    logic [7:0] d;
    busStart();
    sendByte(hdr(1'b1), a);
    check(a, {req, " header ack"}, int'(a), 1);
    readByte(1'b0, d);
    check(d == pat(expPtr), req, int'(d), int'(pat(expPtr)));
    busStop();
    expPtr = (expPtr + 1) % DEPTH;
  endtask

  task automatic randRead(input logic [7:0] hi, input logic [7:0] lo, input int n, string req);
    bit a;
    logic [7:0] d;
    int base;
    base = {hi[4:0], lo};
    busStart();
    sendByte(hdr(1'b0), a); check(a, "R4 write header ack", int'(a), 1);
    sendByte(hi, a);        check(a, "R4 high address ack", int'(a), 1);
    sendByte(lo, a);        check(a, "R4 low address ack", int'(a), 1);
    busStart();
    sendByte(hdr(1'b1), a); check(a, "R4 read header ack", int'(a), 1);
    for (int i = 0; i < n; i++) begin
      readByte(i < n - 1, d);
      check(d == pat((base + i) % DEPTH), req, int'(d), int'(pat((base + i) % DEPTH)));
    end
    busStop();
    expPtr = (base + n) % DEPTH;
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    check(sdaOe == 1'b0, "R1 reset sdaOe", int'(sdaOe), 0);
    rstN = 1'b1;
    // R11 preload every location, verified through later reads
    for (int k = 0; k < DEPTH; k++) begin
      loadEn = 1'b1; loadAddr = ADDR_W'(k); loadData = pat(k);
      @(negedge clk);
    end
    loadEn = 1'b0;
    waitQ();
    check(sdaOe == 1'b0, "R1 idle after preload", int'(sdaOe), 0);

    curRead("R1 R3 R11 pointer starts at 0");
    curRead("R7 next current read");

    // R2 sweep of all strap values, matched and mismatched headers
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      curRead("R2 matched strap read");
      busStart();
      sendByte({4'b1010, 3'(s) ^ 3'b001, 1'b1}, a);
      check(!a, "R2 mismatched strap nack", int'(a), 0);
      readByte(1'b0, d);
      check(d == 8'hFF, "R2 silent after mismatch", int'(d), 8'hFF);
      busStop();
    end
    strap = 3'b101;
    busStart();
    sendByte({4'b1011, strap, 1'b1}, a);
    check(!a, "R2 wrong prefix nack", int'(a), 0);
    busStop();
    curRead("R2 R7 pointer untouched by ignored header");

    randRead(8'hE3, 8'h45, 1, "R4 random read, top bits ignored");
    curRead("R7 pointer advanced after random read");
    randRead(8'h01, 8'h00, 16, "R5 sequential read");
    randRead(8'h1F, 8'hFE, 4, "R6 wrap at end of array");
    randRead(8'hFF, 8'hFF, 2, "R6 wrap from last location");
    curRead("R7 current read after wrap");

    // R8 bare write header and address, then STOP
    busStart();
    sendByte(hdr(1'b0), a); check(a, "R8 header ack", int'(a), 1);
    sendByte(8'h0A, a);     check(a, "R8 high ack", int'(a), 1);
    sendByte(8'h00, a);     check(a, "R8 low ack", int'(a), 1);
    busStop();
    expPtr = 16'h0A00;
    curRead("R8 read at loaded pointer");

    // R9 repeated START in the middle of the low address byte
    busStart();
    sendByte(hdr(1'b0), a);
    sendByte(8'h05, a);
    writeBit(1'b0); writeBit(1'b1); writeBit(1'b1);
    busStart();
    sendByte(hdr(1'b1), a);
    check(a, "R9 header after abort ack", int'(a), 1);
    readByte(1'b0, d);
    check(d == pat(expPtr), "R9 pointer kept after aborted address", int'(d), int'(pat(expPtr)));
    busStop();
    expPtr = (expPtr + 1) % DEPTH;

    // R9 STOP in the middle of a header
    busStart();
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b1); writeBit(1'b0);
    busStop();
    check(sdaOe == 1'b0, "R9 released after STOP", int'(sdaOe), 0);
    curRead("R9 normal read after aborted header");

    check(oeViol == 0, "R10 sdaOe changes only with SCL low", oeViol, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule